// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This block turns a one-byte power control word into five clock-domain enables: core, peripheral, PLL, oscillator/timer and external-interrupt. It also produces a divided core clock enable, a one-cycle strobe that marks each tick of the core clock after it is divided by a power of two.

Software writes the byte through a single write strobe. The block holds one of five nested power modes. In each mode a fixed subset of domains stays on. Wake-up events from four external interrupt lines and a timer return the block from its low-power modes.

Any return to full operation passes through a settle phase. The settle phase lasts a programmable number of cycles and stands in for oscillator and PLL start-up. During settle every domain except the core is running. After settle the core enable rises and the divider strobe starts counting from zero.

The controller is a six-state machine with these states:
- `ST_ACTIVE`
- `ST_PAUSE`
- `ST_NAP`
- `ST_SLEEP`
- `ST_STOP`
- `ST_SETTLE`

It has these transitions:
- **write-enter**: a valid write of a low-power code moves to that mode, from any state.
- **write-resume**: a write of the Active code from any state other than `ST_ACTIVE` goes to `ST_SETTLE`. In `ST_SETTLE` itself this write keeps the state and does not reload the counter.
- **event-wake**: an interrupt or timer event moves Pause, Nap or Sleep to `ST_SETTLE`.
- **irq-wake**: an interrupt event alone moves Stop to `ST_SETTLE`.
- **settle-done**: an expired settle counter moves `ST_SETTLE` to `ST_ACTIVE`.
- **hold**: with none of the above, the state is kept.

Top module: `pm_gate_top`

## Requirements
- R1: After reset the block is in Active with divider 3. All five enables are high, and the first `core_tick` falls on the 8th cycle after reset is released.
- R2: The enables, in the order {core, periph, pll, osc, xirq}, are:
  - Active: 11111
  - Pause: 01111
  - Nap: 00111
  - Sleep: 00011
  - Stop: 00001
  - Settle: 01111
- R3: In the control byte, the mode code is bits 6:4 and the divider is bits 2:0. Bits 7 and 3 have no effect. The mode codes are 000 Active, 001 Pause, 010 Nap, 011 Sleep and 100 Stop.
- R4: A write with mode code 101, 110 or 111 leaves the mode unchanged, but the divider field is still taken.
- R5: In Pause, Nap or Sleep, a high on any `wake_irq` bit or on `wake_tmr` starts the settle phase.
- R6: In Stop, `wake_tmr` is ignored and only a `wake_irq` bit starts the settle phase.
- R7: After the clock edge that starts settle, `en_core` stays low for `settle_len`+1 cycles and then goes high. The other four enables are high during that time.
- R8: While `en_core` is high, `core_tick` is high for one cycle in every 2^CD cycles. With CD=0 it is high every cycle. It is never high while `en_core` is low.
- R9: The divider count restarts from zero on every control write and whenever the core is off. The first tick after either event falls on the 2^CD-th cycle.
- R10: A control write takes priority over a wake event in the same cycle.
- R11: Writing the Active code while in a low-power mode goes through the settle phase, not straight to Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte: mode in 6:4, divider in 2:0 |
| wake_irq | input | 4 | External interrupt wake lines |
| wake_tmr | input | 1 | Timer wake event |
| settle_len | input | 8 | Settle phase length minus one, in cycles |
| en_core | output | 1 | Core domain enable |
| en_periph | output | 1 | Peripheral domain enable |
| en_pll | output | 1 | PLL domain enable |
| en_osc | output | 1 | Oscillator/timer domain enable |
| en_xirq | output | 1 | External-interrupt domain enable |
| core_tick | output | 1 | One-cycle strobe per divided core clock tick |

## Verification
The bench holds a timer event high in Stop for several cycles. A design that let the timer through would wake into settle and raise the PLL and oscillator enables.

It writes reserved mode codes from Nap and from Active. A design that decoded them would fall into some other enable pattern, and one that dropped the whole write would keep the old tick period.

It counts the cycles of core-off settle after wakes with lengths 5 and 0. A counter off by one in either direction shows as a wrong count.

It measures the first tick after writes and wakes, and the tick period at CD 0, 1, 2, 3 and 7. It also drives a Stop write and an interrupt in the same cycle. A design that let the wake win would end up in settle rather than Stop.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_PAUSE,
        ST_NAP,
        ST_SLEEP,
        ST_STOP,
        ST_SETTLE
    } pm_state_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic pll;
        logic osc;
        logic xirq;
    } pm_dom_t;

    // Mode code to target state; valid is low for reserved codes.
    function automatic logic code_to_state(input logic [MODE_W-1:0] code,
                                           output pm_state_e st);
        logic ok;
        ok = 1'b1;
        st = ST_ACTIVE;
        unique case (code)
            3'd0: st = ST_ACTIVE;
            3'd1: st = ST_PAUSE;
            3'd2: st = ST_NAP;
            3'd3: st = ST_SLEEP;
            3'd4: st = ST_STOP;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic pm_dom_t dom_of(input pm_state_e st);
        pm_dom_t d;
        d = '0;
        unique case (st)
            ST_ACTIVE: d = '{core: 1'b1, periph: 1'b1, pll: 1'b1, osc: 1'b1, xirq: 1'b1};
            ST_PAUSE:  d = '{core: 1'b0, periph: 1'b1, pll: 1'b1, osc: 1'b1, xirq: 1'b1};
            ST_SETTLE: d = '{core: 1'b0, periph: 1'b1, pll: 1'b1, osc: 1'b1, xirq: 1'b1};
            ST_NAP:    d = '{core: 1'b0, periph: 1'b0, pll: 1'b1, osc: 1'b1, xirq: 1'b1};
            ST_SLEEP:  d = '{core: 1'b0, periph: 1'b0, pll: 1'b0, osc: 1'b1, xirq: 1'b1};
            ST_STOP:   d = '{core: 1'b0, periph: 1'b0, pll: 1'b0, osc: 1'b0, xirq: 1'b1};
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pm_settle.sv
module pm_settle #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                run,
    input  logic [SETTLE_W-1:0] len,
    output logic                done
);

    logic [SETTLE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);

endmodule

// File: rtl/pm_clkdiv.sv
module pm_clkdiv #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] cd,
    output logic             tick
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // 2^cd - 1; for the largest cd the shift wraps to zero and gives all ones.
    assign limit = (CNT_W'(1) << cd) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == limit);

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
#(
    parameter int CFG_W     = 8,
    parameter int DIV_W     = 3,
    parameter int MODE_LSB  = 4,
    parameter int N_IRQ     = 4,
    parameter int RESET_DIV = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [N_IRQ-1:0] wake_irq,
    input  logic             wake_tmr,
    input  logic             settle_done,
    output logic             settle_load,
    output logic             settle_run,
    output logic [DIV_W-1:0] div_q,
    output pm_dom_t          dom
);

    logic [MODE_W-1:0] mode_fld;
    logic [DIV_W-1:0]  div_fld;
    logic              cfg_unused;
    pm_state_e         st_q, st_d, tgt;
    logic              tgt_ok;
    logic              any_irq;

    assign mode_fld   = cfg_data[MODE_LSB +: MODE_W];
    assign div_fld    = cfg_data[DIV_W-1:0];
    assign cfg_unused = ^{cfg_data[CFG_W-1], cfg_data[MODE_LSB-1:DIV_W]};
    assign any_irq    = |wake_irq;

    always_comb begin
        tgt_ok = code_to_state(mode_fld, tgt);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_ACTIVE;
            div_q <= DIV_W'(RESET_DIV);
        end else begin
            st_q <= st_d;
            if (cfg_wr) begin
                div_q <= div_fld;
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (cfg_wr && tgt_ok) begin
            if (tgt == ST_ACTIVE) begin
                st_d = (st_q == ST_ACTIVE) ? ST_ACTIVE : ST_SETTLE;
            end else begin
                st_d = tgt;
            end
        end else begin
            unique case (st_q)
                ST_ACTIVE: st_d = ST_ACTIVE;
                ST_PAUSE, ST_NAP, ST_SLEEP: begin
                    if (any_irq || wake_tmr) st_d = ST_SETTLE;
                end
                ST_STOP: begin
                    if (any_irq) st_d = ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (settle_done) st_d = ST_ACTIVE;
                end
                default: st_d = ST_ACTIVE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        dom         = dom_of(st_q);
        settle_run  = (st_q == ST_SETTLE);
        settle_load = (st_d == ST_SETTLE) && (st_q != ST_SETTLE);
    end

endmodule

// File: rtl/pm_gate_top.sv
module pm_gate_top
    import pm_pkg::*;
#(
    parameter int CFG_W     = 8,
    parameter int DIV_W     = 3,
    parameter int MODE_LSB  = 4,
    parameter int N_IRQ     = 4,
    parameter int SETTLE_W  = 8,
    parameter int RESET_DIV = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_W-1:0]    cfg_data,
    input  logic [N_IRQ-1:0]    wake_irq,
    input  logic                wake_tmr,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                en_core,
    output logic                en_periph,
    output logic                en_pll,
    output logic                en_osc,
    output logic                en_xirq,
    output logic                core_tick
);

    pm_dom_t          dom;
    logic             s_load, s_run, s_done;
    logic [DIV_W-1:0] div_q;

    pm_mode_fsm #(
        .CFG_W(CFG_W), .DIV_W(DIV_W), .MODE_LSB(MODE_LSB),
        .N_IRQ(N_IRQ), .RESET_DIV(RESET_DIV)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .wake_irq(wake_irq), .wake_tmr(wake_tmr), .settle_done(s_done),
        .settle_load(s_load), .settle_run(s_run), .div_q(div_q), .dom(dom)
    );

    pm_settle #(.SETTLE_W(SETTLE_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(s_load), .run(s_run),
        .len(settle_len), .done(s_done)
    );

    pm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(dom.core), .restart(cfg_wr),
        .cd(div_q), .tick(core_tick)
    );

    assign en_core   = dom.core;
    assign en_periph = dom.periph;
    assign en_pll    = dom.pll;
    assign en_osc    = dom.osc;
    assign en_xirq   = dom.xirq;

endmodule

// File: rtl/pm_gate_checks.sv
module pm_gate_checks #(
    parameter int CFG_W = 8,
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_data,
    input logic [N_IRQ-1:0] wake_irq,
    input logic             wake_tmr,
    input logic             en_core,
    input logic             en_periph,
    input logic             en_pll,
    input logic             en_osc,
    input logic             en_xirq,
    input logic             core_tick
);

    logic [4:0] en_vec;
    assign en_vec = {en_core, en_periph, en_pll, en_osc, en_xirq};

    p_nested_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_core |-> (en_periph && en_pll && en_osc && en_xirq));

    p_tick_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
        core_tick |-> en_core);

    p_stop_tmr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == 5'b00001 && wake_tmr && wake_irq == '0 && !cfg_wr)
        |=> $stable(en_vec));

    p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data[6:4] > 3'd4 && wake_irq == '0 && !wake_tmr
         && !(en_periph && !en_core))
        |=> $stable(en_vec));

    p_settle_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_core) |-> $past(en_periph && en_pll && !en_core));

    p_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data[6:4] == 3'd4) |=> (en_vec == 5'b00001));

endmodule

bind pm_gate_top pm_gate_checks #(.CFG_W(CFG_W), .N_IRQ(N_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .wake_irq(wake_irq), .wake_tmr(wake_tmr), .en_core(en_core),
    .en_periph(en_periph), .en_pll(en_pll), .en_osc(en_osc),
    .en_xirq(en_xirq), .core_tick(core_tick)
);

// File: tb/tb_pm_gate_top.sv
`timescale 1ns/1ps
module tb_pm_gate_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic [3:0] wake_irq = 4'h0;
    logic       wake_tmr = 1'b0;
    logic [7:0] settle_len = 8'd5;
    logic       en_core, en_periph, en_pll, en_osc, en_xirq, core_tick;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pm_gate_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .wake_irq(wake_irq), .wake_tmr(wake_tmr), .settle_len(settle_len),
        .en_core(en_core), .en_periph(en_periph), .en_pll(en_pll),
        .en_osc(en_osc), .en_xirq(en_xirq), .core_tick(core_tick)
    );

    localparam logic [4:0] D_ACT = 5'b11111, D_PAU = 5'b01111, D_NAP = 5'b00111,
                           D_SLP = 5'b00011, D_STP = 5'b00001, D_SET = 5'b01111;

    function automatic logic [4:0] dvec();
        return {en_core, en_periph, en_pll, en_osc, en_xirq};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] b);
        @(negedge clk);
        cfg_data = b;
        cfg_wr   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_wake(input logic [3:0] irq, input logic tmr);
        @(negedge clk);
        wake_irq = irq;
        wake_tmr = tmr;
        @(posedge clk);
        @(negedge clk);
        wake_irq = 4'h0;
        wake_tmr = 1'b0;
    endtask

    // Counts cycles from the current one until the first tick.
    task automatic first_tick(output int n);
        n = 1;
        while (!core_tick && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic tick_period(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!core_tick && n < 1000);
    endtask

    // Counts core-off cycles from the current one.
    task automatic core_off_len(output int n);
        n = 0;
        while (!en_core && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset enables", dvec(), D_ACT);
        first_tick(n);
        check("R1 first tick after reset", n, 8);
        tick_period(n);
        check("R1 reset period", n, 8);
    endtask

    task automatic t_modes();
        int n;
        write_cfg(8'h13); check("R2 pause", dvec(), D_PAU);
        write_cfg(8'h23); check("R2 nap", dvec(), D_NAP);
        write_cfg(8'h33); check("R2 sleep", dvec(), D_SLP);
        write_cfg(8'h43); check("R2 stop", dvec(), D_STP);
        write_cfg(8'h03); check("R11 resume via settle", dvec(), D_SET);
        core_off_len(n);
        check("R11 settle length on active write", n, 6);
        check("R2 active", dvec(), D_ACT);
    endtask

    task automatic t_fields();
        int n;
        write_cfg(8'h8A);
        check("R3 bits 7/3 ignored, active kept", dvec(), D_ACT);
        first_tick(n);
        check("R3 divider field bits 2:0 (CD=2)", n, 4);
        write_cfg(8'h98);
        check("R3 mode field bits 6:4 to pause", dvec(), D_PAU);
        write_cfg(8'h00);
        core_off_len(n);
        first_tick(n);
        check("R8 CD=0 tick first cycle", n, 1);
        tick_period(n);
        check("R8 CD=0 period", n, 1);
    endtask

    task automatic t_reserved();
        int n;
        write_cfg(8'h51);
        check("R4 reserved keeps active", dvec(), D_ACT);
        first_tick(n);
        check("R4 divider taken on reserved write", n, 2);
        write_cfg(8'h23);
        write_cfg(8'h53); check("R4 code 101 keeps nap", dvec(), D_NAP);
        write_cfg(8'h63); check("R4 code 110 keeps nap", dvec(), D_NAP);
        write_cfg(8'h73); check("R4 code 111 keeps nap", dvec(), D_NAP);
    endtask

    task automatic t_wakes();
        int n;
        // nap woken by the timer
        pulse_wake(4'h0, 1'b1);
        check("R5 nap timer wake -> settle", dvec(), D_SET);
        core_off_len(n);
        check("R7 settle len 5", n, 6);
        first_tick(n);
        check("R9 first tick after wake (CD=3)", n, 8);
        // sleep woken by irq line 2, zero settle
        settle_len = 8'd0;
        write_cfg(8'h31);
        check("R2 sleep again", dvec(), D_SLP);
        pulse_wake(4'h4, 1'b0);
        check("R5 sleep irq wake -> settle", dvec(), D_SET);
        core_off_len(n);
        check("R7 settle len 0", n, 1);
        first_tick(n);
        check("R9 first tick after wake (CD=1)", n, 2);
        settle_len = 8'd5;
        // pause woken by irq line 3
        write_cfg(8'h13);
        pulse_wake(4'h8, 1'b0);
        check("R5 pause irq wake -> settle", dvec(), D_SET);
        core_off_len(n);
        check("R7 settle after pause", n, 6);
    endtask

    task automatic t_stop();
        int n;
        write_cfg(8'h43);
        @(negedge clk);
        wake_tmr = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 stop ignores timer", dvec(), D_STP);
        wake_tmr = 1'b0;
        @(negedge clk);
        check("R6 stop still after timer", dvec(), D_STP);
        pulse_wake(4'h1, 1'b0);
        check("R6 stop irq wake -> settle", dvec(), D_SET);
        core_off_len(n);
        check("R6 back to active", dvec(), D_ACT);
    endtask

    task automatic t_priority();
        write_cfg(8'h33);
        @(negedge clk);
        cfg_data = 8'h43;
        cfg_wr   = 1'b1;
        wake_irq = 4'h2;
        @(posedge clk);
        @(negedge clk);
        cfg_wr   = 1'b0;
        wake_irq = 4'h0;
        check("R10 write beats wake", dvec(), D_STP);
        @(negedge clk);
        check("R10 stays in stop", dvec(), D_STP);
    endtask

    task automatic t_divider();
        int n;
        int n2;
        write_cfg(8'h03);
        core_off_len(n);
        write_cfg(8'h07);
        first_tick(n);
        check("R9 first tick after write (CD=7)", n, 128);
        tick_period(n);
        check("R8 CD=7 period", n, 128);
        write_cfg(8'h02);
        first_tick(n);
        tick_period(n2);
        check("R8 CD=2 period", n2, 4);
        @(negedge clk);
        check("R8 tick one cycle wide", core_tick, 0);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_fields();
        t_reserved();
        t_wakes();
        t_stop();
        t_priority();
        t_divider();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule